// File: doc/BRIEF.md
# Edge Timestamp Capture Queue

This block records when things happen on one digital I/O channel. On every rising edge of the already synchronized channel level, and on every start of a pulse produced by the channel's own output generator, it takes the current value of an external time reference, a whole-seconds count and a sub-second count of 8 ns cycles. It writes that pair as one entry into a first-in first-out store. Input edges and self-generated pulses land in the same store in the order they occurred.

Software drains the store through a two-word read. It sees the oldest entry on the head outputs. It first signals a read of the seconds word, then signals a read of the cycles word, and that second read removes the entry. The interrupt line stays high for as long as any entry is waiting. If events arrive while the store is full, they are discarded and a sticky overflow flag records the loss until software clears it.

Top module: `ts_capture_fifo`

## Requirements
- R1: A rising edge of `chan_i` writes exactly one entry, holding the `tref_sec_i`/`tref_cyc_i` values present in the cycle in which `chan_i` is first seen high. A level held high or a falling edge writes nothing.
- R2: A cycle with `pulse_start_i` high writes one entry with that cycle's time reference. If a rising edge of `chan_i` falls in the same cycle, still only one entry is written.
- R3: `head_sec_o`/`head_cyc_o` show the seconds and cycles fields of the oldest stored entry, in order of arrival. Both read zero while the store is empty.
- R4: A `rd_cyc_i` pulse removes the head entry only if `rd_sec_i` was pulsed in an earlier cycle since the last removal. Otherwise, or when the store is empty, it has no effect on `level_o`.
- R5: `level_o` equals the number of stored entries, from 0 up to DEPTH (default 256). It rises by one on the edge after an accepted event and falls by one on the edge after a removal.
- R6: An event arriving while the store holds DEPTH entries and no removal occurs is dropped. The level and the head do not change, and `ovf_o` goes high on the next edge.
- R7: `ovf_o` stays high until a cycle with `ovf_clr_i` high clears it. A drop in the same cycle as the clear keeps it high.
- R8: `irq_o` is high exactly while `level_o` is non-zero. It stays high, not just for a single cycle.
- R9: After reset, `level_o` is 0, `irq_o` and `ovf_o` are low, and the head outputs are zero.
- R10: When the store is full and a removal and an event occur in the same cycle, the event is kept. The level stays at DEPTH and nothing is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| chan_i | input | 1 | Synchronized channel level |
| pulse_start_i | input | 1 | Output generator pulse start, one cycle |
| tref_sec_i | input | SEC_W | Time reference, seconds |
| tref_cyc_i | input | CYC_W | Time reference, 8 ns cycles within the second |
| rd_sec_i | input | 1 | Seconds word read strobe (arms removal) |
| rd_cyc_i | input | 1 | Cycles word read strobe (removes head if armed) |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| head_sec_o | output | SEC_W | Seconds field of the oldest entry |
| head_cyc_o | output | CYC_W | Cycles field of the oldest entry |
| level_o | output | $clog2(DEPTH+1) | Number of stored entries |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | High while entries are stored |

## Verification
A corrupted read or write pointer shows up on the head outputs at the very next read-back. The bench catches it by comparing every drained entry against its own model of the arrival order. A wrong entry count shows on `level_o` and `irq_o` one edge after the faulty update. A lost or stuck removal arming shows as a level that does not move, or moves too early, in the cycle after the cycles-word strobe. Filling the store to exactly its depth exposes wrap-around and full-boundary faults: these show as a missing overflow flag, a level past DEPTH, or a head out of sequence during the final drain.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
    localparam int TS_SEC_W = 32;
    localparam int TS_CYC_W = 28;
    localparam int TS_DEPTH = 256;

    typedef struct packed {
        logic prev;
    } det_state_t;

    typedef struct packed {
        logic armed;
    } rd_state_t;
endpackage

// File: rtl/ts_evt_detect.sv
module ts_evt_detect #(
    parameter int SEC_W = ts_cap_pkg::TS_SEC_W,
    parameter int CYC_W = ts_cap_pkg::TS_CYC_W,
    localparam int W = SEC_W + CYC_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             chan_i,
    input  logic             pulse_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [CYC_W-1:0] cyc_i,
    output logic             evt_o,
    output logic [W-1:0]     stamp_o
);
    import ts_cap_pkg::*;

    det_state_t st_d, st_q;

    always_comb begin
        st_d.prev = chan_i;
        // Edge and pulse in one cycle merge into one event.
        evt_o     = (chan_i & ~st_q.prev) | pulse_i;
        stamp_o   = {sec_i, cyc_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/ts_pop_ctrl.sv
module ts_pop_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rd_sec_i,
    input  logic rd_cyc_i,
    input  logic empty_i,
    output logic pop_o,
    output logic armed_o
);
    import ts_cap_pkg::*;

    rd_state_t st_d, st_q;

    always_comb begin
        pop_o = rd_cyc_i & st_q.armed & ~empty_i;
        st_d  = st_q;
        if (pop_o)    st_d.armed = 1'b0;
        if (rd_sec_i) st_d.armed = 1'b1;
        armed_o = st_q.armed;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/ts_fifo_store.sv
module ts_fifo_store #(
    parameter int W     = ts_cap_pkg::TS_SEC_W + ts_cap_pkg::TS_CYC_W,
    parameter int DEPTH = ts_cap_pkg::TS_DEPTH,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic [W-1:0]  din_i,
    input  logic          pop_i,
    input  logic          ovf_clr_i,
    output logic [W-1:0]  dout_o,
    output logic [CW-1:0] level_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          ovf_o
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic accept, drop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        empty_o = (st_q.cnt == '0);
        full_o  = (st_q.cnt == CW'(DEPTH));
        accept  = push_i & (~full_o | pop_i);
        drop    = push_i & full_o & ~pop_i;
        st_d    = st_q;
        if (accept) st_d.wr = bump(st_q.wr);
        if (pop_i)  st_d.rd = bump(st_q.rd);
        case ({accept, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (ovf_clr_i) st_d.ovf = 1'b0;
        if (drop)      st_d.ovf = 1'b1;
        dout_o  = empty_o ? '0 : mem[st_q.rd];
        level_o = st_q.cnt;
        ovf_o   = st_q.ovf;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (accept) mem[st_q.wr] <= din_i;
    end
endmodule

// File: rtl/ts_capture_fifo.sv
module ts_capture_fifo #(
    parameter int SEC_W = ts_cap_pkg::TS_SEC_W,
    parameter int CYC_W = ts_cap_pkg::TS_CYC_W,
    parameter int DEPTH = ts_cap_pkg::TS_DEPTH,
    localparam int W    = SEC_W + CYC_W,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             chan_i,
    input  logic             pulse_start_i,
    input  logic [SEC_W-1:0] tref_sec_i,
    input  logic [CYC_W-1:0] tref_cyc_i,
    input  logic             rd_sec_i,
    input  logic             rd_cyc_i,
    input  logic             ovf_clr_i,
    output logic [SEC_W-1:0] head_sec_o,
    output logic [CYC_W-1:0] head_cyc_o,
    output logic [CW-1:0]    level_o,
    output logic             ovf_o,
    output logic             irq_o
);
    logic         evt, pop, armed, empty, full;
    logic [W-1:0] stamp, head;

    ts_evt_detect #(.SEC_W(SEC_W), .CYC_W(CYC_W)) u_det (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .chan_i  (chan_i),
        .pulse_i (pulse_start_i),
        .sec_i   (tref_sec_i),
        .cyc_i   (tref_cyc_i),
        .evt_o   (evt),
        .stamp_o (stamp)
    );

    ts_pop_ctrl u_rd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_sec_i (rd_sec_i),
        .rd_cyc_i (rd_cyc_i),
        .empty_i  (empty),
        .pop_o    (pop),
        .armed_o  (armed)
    );

    ts_fifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (evt),
        .din_i     (stamp),
        .pop_i     (pop),
        .ovf_clr_i (ovf_clr_i),
        .dout_o    (head),
        .level_o   (level_o),
        .empty_o   (empty),
        .full_o    (full),
        .ovf_o     (ovf_o)
    );

    assign head_sec_o = head[W-1:CYC_W];
    assign head_cyc_o = head[CYC_W-1:0];
    assign irq_o      = ~empty;
endmodule

// File: rtl/ts_capture_fifo_chk.sv
module ts_capture_fifo_chk #(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          evt,
    input logic          pop,
    input logic          armed,
    input logic          full,
    input logic          rd_cyc_i,
    input logic          ovf_clr_i,
    input logic [CW-1:0] level_o,
    input logic          ovf_o,
    input logic          irq_o
);
    // R5: count never exceeds capacity
    assert_level_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= CW'(DEPTH));

    // R8: an event into an empty store raises the interrupt next cycle
    assert_irq_on_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o == '0 && evt) |=> irq_o);

    // R6: a drop keeps the level and sets the flag
    assert_full_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full && evt && !pop) |=> (ovf_o && level_o == CW'(DEPTH)));

    // R7: the flag is sticky without a clear
    assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    // R4: an unarmed cycles-word read does not remove anything
    assert_unarmed_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_cyc_i && !armed && !evt) |=> $stable(level_o));
endmodule

bind ts_capture_fifo ts_capture_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt       (evt),
    .pop       (pop),
    .armed     (armed),
    .full      (full),
    .rd_cyc_i  (rd_cyc_i),
    .ovf_clr_i (ovf_clr_i),
    .level_o   (level_o),
    .ovf_o     (ovf_o),
    .irq_o     (irq_o)
);

// File: tb/ts_capture_fifo_tb.sv
`timescale 1ns/1ps
module ts_capture_fifo_tb;
    localparam int SEC_W = 32;
    localparam int CYC_W = 28;
    localparam int DEPTH = 256;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NV    = 8;

    // {chan, pulse, sec, cyc}
    localparam logic [61:0] VEC [NV] = '{
        {1'b1, 1'b0, 32'h0000_0010, 28'h000_0001},
        {1'b1, 1'b0, 32'h0000_0011, 28'h000_0002},
        {1'b0, 1'b0, 32'h0000_0012, 28'h000_0003},
        {1'b0, 1'b1, 32'h0000_0013, 28'h000_0004},
        {1'b1, 1'b1, 32'h0000_0014, 28'h773_5940},
        {1'b0, 1'b0, 32'h0000_0015, 28'h000_0006},
        {1'b1, 1'b0, 32'hFFFF_FFFF, 28'h773_593F},
        {1'b0, 1'b1, 32'h0000_0017, 28'h000_0008}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic chan = 1'b0, pulse = 1'b0, rd_sec = 1'b0, rd_cyc = 1'b0, ovf_clr = 1'b0;
    logic [SEC_W-1:0] sec = '0;
    logic [CYC_W-1:0] cyc = '0;
    logic [SEC_W-1:0] head_sec;
    logic [CYC_W-1:0] head_cyc;
    logic [CW-1:0]    level;
    logic ovf, irq;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    logic [59:0] model [16];
    int m_head = 0, m_cnt = 0;

    always #2.5 clk = ~clk;

    ts_capture_fifo u_dut (
        .clk_i(clk), .rst_ni(rst_n), .chan_i(chan), .pulse_start_i(pulse),
        .tref_sec_i(sec), .tref_cyc_i(cyc), .rd_sec_i(rd_sec), .rd_cyc_i(rd_cyc),
        .ovf_clr_i(ovf_clr), .head_sec_o(head_sec), .head_cyc_o(head_cyc),
        .level_o(level), .ovf_o(ovf), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pop_entry();
        rd_sec = 1'b1; step(); rd_sec = 1'b0;
        rd_cyc = 1'b1; step(); rd_cyc = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit prev = 1'b0;
        int lv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk(level == '0, "R9 level", 64'(level), 0);
        chk(!irq && !ovf, "R9 irq/ovf", {62'b0, irq, ovf}, 0);
        chk(head_sec == '0 && head_cyc == '0, "R9 R3 head zero", 64'({head_sec, head_cyc}), 0);

        // Vector table: R1 edges, R2 pulses and merge, R5 level, R8 irq
        for (int i = 0; i < NV; i++) begin
            chan = VEC[i][61]; pulse = VEC[i][60];
            sec = VEC[i][59:28]; cyc = VEC[i][27:0];
            step();
            if ((chan && !prev) || pulse) begin
                model[(m_head + m_cnt) % 16] = VEC[i][59:0];
                m_cnt++;
            end
            prev = chan;
            chk(level == CW'(m_cnt), "R1 R2 R5 level", 64'(level), 64'(m_cnt));
            chk(irq == (m_cnt != 0), "R8 irq", 64'(irq), 64'(m_cnt != 0));
        end
        chan = 1'b0; pulse = 1'b0;
        step();

        // R3 read-back in order, R4 armed pop
        while (m_cnt > 0) begin
            chk({head_sec, head_cyc} == model[m_head], "R3 head order",
                64'({head_sec, head_cyc}), 64'(model[m_head]));
            pop_entry();
            m_head = (m_head + 1) % 16; m_cnt--;
            chk(level == CW'(m_cnt), "R4 pop level", 64'(level), 64'(m_cnt));
        end
        chk(!irq, "R8 irq low when drained", 64'(irq), 0);
        chk(head_sec == '0 && head_cyc == '0, "R3 empty head zero", 64'({head_sec, head_cyc}), 0);

        // R4 unarmed cycles read ignored
        pulse = 1'b1; sec = 32'h55; cyc = 28'h66; step(); pulse = 1'b0;
        rd_cyc = 1'b1; step(); rd_cyc = 1'b0; step();
        chk(level == CW'(1), "R4 unarmed read ignored", 64'(level), 1);
        chk(head_cyc == 28'h66, "R4 head kept", 64'(head_cyc), 64'h66);
        pop_entry();
        chk(level == '0, "R4 armed pop", 64'(level), 0);
        // R4 pop on empty while armed
        pop_entry();
        chk(level == '0, "R4 empty pop no effect", 64'(level), 0);
        chk(!irq, "R8 irq stays low", 64'(irq), 0);

        // Fill to DEPTH
        sec = 32'h7;
        for (int i = 0; i < DEPTH; i++) begin
            pulse = 1'b1; cyc = CYC_W'(i); step();
        end
        pulse = 1'b0;
        chk(level == CW'(DEPTH), "R5 full level", 64'(level), DEPTH);
        chk(!ovf, "R6 no overflow at exactly full", 64'(ovf), 0);
        chk(irq, "R8 irq while full", 64'(irq), 1);
        // R6 drop
        pulse = 1'b1; cyc = 28'hABC; step(); pulse = 1'b0;
        chk(level == CW'(DEPTH), "R6 level after drop", 64'(level), DEPTH);
        chk(ovf, "R6 overflow set", 64'(ovf), 1);
        chk(head_cyc == '0, "R6 head unchanged", 64'(head_cyc), 0);
        // R10 pop and event together at full
        rd_sec = 1'b1; step(); rd_sec = 1'b0;
        rd_cyc = 1'b1; pulse = 1'b1; cyc = 28'h3E7; step();
        rd_cyc = 1'b0; pulse = 1'b0;
        chk(level == CW'(DEPTH), "R10 level kept", 64'(level), DEPTH);
        chk(head_cyc == 28'h1, "R10 head advanced", 64'(head_cyc), 1);
        chk(ovf, "R7 sticky", 64'(ovf), 1);
        // R7 clear with simultaneous drop
        ovf_clr = 1'b1; pulse = 1'b1; step(); ovf_clr = 1'b0; pulse = 1'b0;
        chk(ovf, "R7 drop beats clear", 64'(ovf), 1);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        chk(!ovf, "R7 cleared", 64'(ovf), 0);

        // Drain: cycles 1..255 then 0x3E7
        for (int i = 1; i <= DEPTH; i++) begin
            lv = (i == DEPTH) ? 'h3E7 : i;
            chk(head_cyc == CYC_W'(lv) && head_sec == 32'h7, "R3 drain order",
                64'(head_cyc), 64'(lv));
            pop_entry();
        end
        chk(level == '0, "R5 drained", 64'(level), 0);
        chk(!irq, "R8 irq low after drain", 64'(irq), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule